// File: doc/BRIEF.md
# SIMT Warp Issue Scheduler

This block picks which warp a multiprocessor issues next and spreads that warp's instruction over a small set of scalar lanes. Each warp carries a ready flag and an active-thread mask. A warp counts as eligible only when its flag is set and at least one bit of its mask is set. The scheduler grants eligible warps in round-robin order. The search begins at the warp after the one issued most recently.

A granted warp holds the lanes for a whole issue window, and the scheduler moves to another warp only at the end of a window. With the default sizes (32 threads, 8 lanes), a full window lasts four cycles and covers the threads in groups of eight. A mode flag selects a two-cycle window, which covers only the lower half of the threads. In every cycle of a window, each lane is enabled from the mask bit of the thread it serves. When no warp is eligible, the scheduler reports idle and keeps its round-robin position.

Top module: `simt_warp_sched`

## Requirements
- R1: After reset, `idle` is 1, `issue_valid` is 0 and `lane_en` is all zero. The first warp granted is the lowest-numbered eligible warp.
- R2: Warp w is eligible only when `warp_ready[w]` is 1 and its mask, bits `[w*32 +: 32]` of `warp_mask`, is non-zero. A warp that is ready but has an all-zero mask is never issued.
- R3: The scheduler grants eligible warps in round-robin order. It searches upward from the warp after the last issued warp ID and wraps from the highest warp to warp 0.
- R4: In full mode, a granted warp occupies exactly four consecutive cycles. `issue_warp` stays constant and `issue_group` runs 0, 1, 2, 3. No other warp is issued inside the window.
- R5: While issuing, `lane_en[j]` in group k equals bit 8*k+j of the issued warp's mask.
- R6: When `half_mode` is 1 at the start of a window, the window lasts two cycles, with `issue_group` running 0, 1.
- R7: If no warp is eligible at a window boundary, then `idle` is 1, `issue_valid` is 0 and `lane_en` is zero in the next cycle. The round-robin position keeps the last issued warp.
- R8: If a warp is eligible at the end of a window, the next window starts in the very next cycle, with no idle cycle in between.
- R9: `half_mode` is sampled only at the start of a window. Changing it inside a window does not change that window's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_mode | input | 1 | Selects the two-cycle issue window for the next window that starts |
| warp_ready | input | 24 | Per-warp ready flags |
| warp_mask | input | 768 | Per-warp 32-bit active-thread masks; warp w uses bits [w*32 +: 32] |
| issue_valid | output | 1 | A warp is being issued this cycle |
| issue_warp | output | 5 | ID of the issued warp |
| issue_group | output | 2 | Thread group index within the window |
| lane_en | output | 8 | Per-lane enables for this cycle |
| idle | output | 1 | No warp is being issued |

## Verification
The round-robin position after a stretch of idle cycles is hard to observe, because it only shows up in the next grant. The stimulus therefore ends one burst on a known warp and then offers only a ready warp with an empty mask. Next it offers two warps, placed so that a pointer that had moved or been reset would grant the other one first. A second hard case is a mode change inside a window. The bench flips `half_mode` one cycle after a grant and checks that the window still runs all four groups.

// File: rtl/simt_sched_pkg.sv
package simt_sched_pkg;

   typedef enum logic {
      WIN_FULL = 1'b0,
      WIN_HALF = 1'b1
   } win_mode_e;

   // number of thread groups covered by one window in a given mode
   function automatic int win_groups(input win_mode_e m, input int full_groups);
      return (m == WIN_HALF) ? full_groups / 2 : full_groups;
   endfunction

endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
   parameter int NUM_WARPS = 24,
   localparam int WID_W    = $clog2(NUM_WARPS)
) (
   input  logic [NUM_WARPS-1:0] elig,
   input  logic [WID_W-1:0]     last_id,
   output logic                 found,
   output logic [WID_W-1:0]     pick_id
);

   always_comb begin
      found   = 1'b0;
      pick_id = '0;
      for (int i = 1; i <= NUM_WARPS; i++) begin
         int cand;
         cand = int'(last_id) + i;
         if (cand >= NUM_WARPS) cand = cand - NUM_WARPS;
         if (!found && elig[cand]) begin
            found   = 1'b1;
            pick_id = WID_W'(cand);
         end
      end
   end

   always_comb begin
      AST_GRANT_ELIGIBLE: assert (!found || elig[pick_id]); // R2
   end

endmodule

// File: rtl/lane_group_sel.sv
module lane_group_sel #(
   parameter int THREADS   = 32,
   parameter int LANES     = 8,
   localparam int GROUPS   = THREADS / LANES,
   localparam int GRP_W    = $clog2(GROUPS)
) (
   input  logic [THREADS-1:0] mask,
   input  logic [GRP_W-1:0]   group,
   input  logic               enable,
   output logic [LANES-1:0]   lane_en
);

   logic [LANES-1:0] slice [GROUPS];

   for (genvar g = 0; g < GROUPS; g++) begin : g_slice
      assign slice[g] = mask[g*LANES +: LANES];
   end

   assign lane_en = enable ? slice[group] : '0;

endmodule

// File: rtl/simt_warp_sched.sv
module simt_warp_sched
   import simt_sched_pkg::*;
#(
   parameter int NUM_WARPS    = 24,
   parameter int WARP_THREADS = 32,
   parameter int NUM_LANES    = 8,
   parameter bit HALF_MODE_EN = 1'b1,
   localparam int NUM_GROUPS  = WARP_THREADS / NUM_LANES,
   localparam int HALF_GROUPS = NUM_GROUPS / 2,
   localparam int GRP_W       = $clog2(NUM_GROUPS),
   localparam int WID_W       = $clog2(NUM_WARPS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              half_mode,
   input  logic [NUM_WARPS-1:0]              warp_ready,
   input  logic [NUM_WARPS*WARP_THREADS-1:0] warp_mask,
   output logic                              issue_valid,
   output logic [WID_W-1:0]                  issue_warp,
   output logic [GRP_W-1:0]                  issue_group,
   output logic [NUM_LANES-1:0]              lane_en,
   output logic                              idle
);

   // elaboration-time parameter checks
   if (WARP_THREADS % NUM_LANES != 0) begin : g_bad_split
      $error("WARP_THREADS must be a multiple of NUM_LANES");
   end
   if (NUM_GROUPS < 2 || (NUM_GROUPS & (NUM_GROUPS - 1)) != 0) begin : g_bad_groups
      $error("thread groups per warp must be a power of two, at least 2");
   end
   if (NUM_WARPS < 2) begin : g_bad_warps
      $error("NUM_WARPS must be at least 2");
   end

   // per-warp masks and eligibility
   logic [WARP_THREADS-1:0] mask_arr [NUM_WARPS];
   logic [NUM_WARPS-1:0]    elig;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
      assign mask_arr[w] = warp_mask[w*WARP_THREADS +: WARP_THREADS];
      assign elig[w]     = warp_ready[w] & (|mask_arr[w]);
   end

   // window mode variant
   win_mode_e mode_in;
   if (HALF_MODE_EN) begin : g_half_mode
      assign mode_in = half_mode ? WIN_HALF : WIN_FULL;
   end else begin : g_full_only
      assign mode_in = WIN_FULL;
   end

   // scheduler state
   logic             active_q;
   logic [WID_W-1:0] warp_q;
   logic [WID_W-1:0] ptr_q;
   logic [GRP_W-1:0] grp_q;
   win_mode_e        mode_q;
   logic [GRP_W-1:0] last_grp;
   logic             win_end;
   logic             pick_found;
   logic [WID_W-1:0] pick_id;

   assign last_grp = GRP_W'(win_groups(mode_q, NUM_GROUPS) - 1);
   assign win_end  = !active_q || (grp_q == last_grp);

   warp_rr_pick #(
      .NUM_WARPS (NUM_WARPS)
   ) u_pick (
      .elig    (elig),
      .last_id (ptr_q),
      .found   (pick_found),
      .pick_id (pick_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         warp_q   <= '0;
         grp_q    <= '0;
         mode_q   <= WIN_FULL;
         ptr_q    <= WID_W'(NUM_WARPS - 1);
      end else if (win_end) begin
         grp_q <= '0;
         if (pick_found) begin
            active_q <= 1'b1;
            warp_q   <= pick_id;
            ptr_q    <= pick_id;
            mode_q   <= mode_in;
         end else begin
            active_q <= 1'b0;
         end
      end else begin
         grp_q <= grp_q + 1'b1;
      end
   end

   lane_group_sel #(
      .THREADS (WARP_THREADS),
      .LANES   (NUM_LANES)
   ) u_lanes (
      .mask    (mask_arr[warp_q]),
      .group   (grp_q),
      .enable  (active_q),
      .lane_en (lane_en)
   );

   assign issue_valid = active_q;
   assign idle        = !active_q;
   assign issue_warp  = warp_q;
   assign issue_group = grp_q;

   // checks on the sequencing
   AST_MIDWINDOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && grp_q != last_grp) |=> (active_q && warp_q == $past(warp_q)
                                           && grp_q == GRP_W'($past(grp_q) + 1'b1))); // R4

   AST_IDLE_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      !active_q |-> $stable(ptr_q)); // R7

   AST_IDLE_LANES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (lane_en == '0)); // R7

   AST_WINDOW_FROM_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && grp_q == '0) |-> ((($past(elig) >> warp_q) & NUM_WARPS'(1)) != '0)); // R2

   AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && mode_q == WIN_HALF) |-> (grp_q < GRP_W'(HALF_GROUPS))); // R6

   AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && grp_q == last_grp && (|elig)) |=> (active_q && grp_q == '0)); // R8

endmodule

// File: tb/simt_warp_sched_test.sv
`timescale 1ns/1ps
module simt_warp_sched_test;

   localparam int NW = 24;
   localparam int T  = 32;
   localparam int L  = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              half_mode = 1'b0;
   logic [NW-1:0]     ready = '0;
   logic [31:0]       masks [NW];
   logic [NW*T-1:0]   mask_flat;
   logic              issue_valid;
   logic [4:0]        issue_warp;
   logic [1:0]        issue_group;
   logic [L-1:0]      lane_en;
   logic              idle;

   always #2 clk = ~clk;   // 250 MHz

   always_comb begin
      for (int w = 0; w < NW; w++) mask_flat[w*T +: T] = masks[w];
   end

   simt_warp_sched uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .half_mode   (half_mode),
      .warp_ready  (ready),
      .warp_mask   (mask_flat),
      .issue_valid (issue_valid),
      .issue_warp  (issue_warp),
      .issue_group (issue_group),
      .lane_en     (lane_en),
      .idle        (idle)
   );

   typedef struct {
      int         cyc;
      logic       v;
      int         warp;
      int         grp;
      logic [7:0] lanes;
      string      req;
   } item_t;

   item_t sb [$];
   item_t cur;
   int    cnt = 0;
   int    checks = 0;
   int    fails = 0;
   int    exp_ptr = NW - 1;

   always @(posedge clk) cnt <= cnt + 1;

   // monitor: compares outputs against the expected items of this cycle
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].cyc <= cnt) begin
         cur = sb.pop_front();
         checks++;
         if (cur.cyc < cnt) begin
            fails++;
            $display("FAIL %s: expected item for cycle %0d was skipped (now %0d)", cur.req, cur.cyc, cnt);
         end else if (issue_valid !== cur.v || idle !== !cur.v || lane_en !== cur.lanes ||
                      (cur.v && (int'(issue_warp) != cur.warp || int'(issue_group) != cur.grp))) begin
            fails++;
            $display("FAIL %s cyc %0d: valid=%0b idle=%0b warp=%0d grp=%0d lanes=%h, expected valid=%0b warp=%0d grp=%0d lanes=%h",
                     cur.req, cnt, issue_valid, idle, issue_warp, issue_group, lane_en,
                     cur.v, cur.warp, cur.grp, cur.lanes);
         end
      end
   end

   function automatic int rr_next(input int last, input logic [NW-1:0] el);
      for (int i = 1; i <= NW; i++) begin
         if (el[(last + i) % NW]) return (last + i) % NW;
      end
      return -1;
   endfunction

   task automatic push(input int cyc, input logic v, input int warp, input int grp,
                       input logic [7:0] lanes, input string req);
      item_t it;
      it.cyc = cyc; it.v = v; it.warp = warp; it.grp = grp; it.lanes = lanes; it.req = req;
      sb.push_back(it);
   endtask

   // driver: offers a ready set, predicts the windows, then withdraws it
   task automatic run(input logic [NW-1:0] rdy, input bit half, input int nwin,
                      input bit flip, input string req);
      logic [NW-1:0] el;
      int base, len, p, total;
      @(posedge clk); #1;
      ready = rdy;
      half_mode = half;
      for (int w = 0; w < NW; w++) el[w] = rdy[w] && (masks[w] != 0);
      base  = cnt + 1;
      len   = half ? 2 : 4;
      total = nwin * len;
      for (int k = 0; k < nwin; k++) begin
         p = rr_next(exp_ptr, el);
         for (int g = 0; g < len; g++) begin
            if (p < 0) push(base + k*len + g, 1'b0, 0, 0, 8'h00, req);
            else       push(base + k*len + g, 1'b1, p, g, masks[p][g*8 +: 8], req);
         end
         if (p >= 0) exp_ptr = p;
      end
      push(base + total,     1'b0, 0, 0, 8'h00, req);
      push(base + total + 1, 1'b0, 0, 0, 8'h00, req);
      if (flip) begin
         @(posedge clk); #1;
         half_mode = !half_mode;
         repeat (total - 1) @(posedge clk);
      end else begin
         repeat (total) @(posedge clk);
      end
      #1;
      ready = '0;
      half_mode = 1'b0;
      repeat (3) @(posedge clk);
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish (expected completion)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int w = 0; w < NW; w++) masks[w] = '0;
      masks[0]  = 32'h00FF_00FF;
      masks[3]  = 32'hFFFF_FFFF;
      masks[5]  = 32'h8421_0F0F;
      masks[7]  = 32'h0000_0000;
      masks[9]  = 32'h0000_0001;
      masks[23] = 32'hF000_0000;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (idle !== 1'b1 || issue_valid !== 1'b0 || lane_en !== '0) begin
         fails++;
         $display("FAIL R1 reset: idle=%0b valid=%0b lanes=%h, expected idle=1 valid=0 lanes=00",
                  idle, issue_valid, lane_en);
      end

      // R1: first grant goes to the lowest eligible warp
      run((NW'(1) << 0) | (NW'(1) << 3), 1'b0, 1, 1'b0, "R1 first grant");
      // R2 R3 R4 R5 R8: two warps alternate, empty-mask warp 7 skipped
      run((NW'(1) << 3) | (NW'(1) << 5) | (NW'(1) << 7), 1'b0, 4, 1'b0, "R2 R3 R4 R5 R8");
      // R2 R7: only a ready warp with an empty mask, scheduler stays idle
      run(NW'(1) << 7, 1'b0, 1, 1'b0, "R2 R7 empty mask");
      // R3 R7: pointer kept at 5 across idle, so 9 precedes 3
      run((NW'(1) << 3) | (NW'(1) << 9), 1'b0, 2, 1'b0, "R3 R7 pointer kept");
      // R6 R3: half windows with wrap between 23 and 0
      run((NW'(1) << 0) | (NW'(1) << 23), 1'b1, 3, 1'b0, "R6 R3 half wrap");
      // R9: mode flag flipped inside a full window
      run(NW'(1) << 0, 1'b0, 1, 1'b1, "R9 mid-window flag");
      // R6 R5: half windows with sparse masks
      run((NW'(1) << 5) | (NW'(1) << 9), 1'b1, 2, 1'b0, "R6 R5 half lanes");

      repeat (2) @(posedge clk);
      @(negedge clk);
      checks++;
      if (sb.size() != 0) begin
         fails++;
         $display("FAIL R4 scoreboard: %0d items left, expected 0", sb.size());
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule